// File: doc/BRIEF.md
# Nibble-Wide Serial Register Port

This block is a four-wire serial slave port through which a host microcontroller reads and writes a small bank of 4-bit control registers. The host pulls the active-low select low, drives a serial clock and a data line, and exchanges exactly one 8-bit frame. The frame opens with a command nibble: one direction bit followed by a 3-bit address. A data nibble follows it. Incoming bits are captured on rising clock edges. During a read, the port drives the addressed nibble out MSB first on falling edges, starting straight after the command nibble. The data output is modelled as a value plus an output-enable, so the pad stage can form a tri-state driver.

Seven registers exist, at addresses 0 to 6. Addresses 0 to 5 are read/write and are held in the system clock domain. Their contents are exposed as a flat vector for the rest of the chip. Bit 0 of register 0 has no function: it reads as zero and cannot be written. Register 6 is read-only and reflects a status nibble supplied from outside. Address 7 is accepted on the wire but holds nothing.

The serial-clock side has four phases, named CMD, WDATA, RDATA and DONE. A frame starts in CMD. After four command bits it moves from CMD to WDATA (write) or from CMD to RDATA (read). After four data bits it moves from WDATA or RDATA to DONE, and stays there until the select rises. A rising select takes any phase back to CMD. A completed write is captured in the serial domain and passed to the system clock as a toggle through a two-flop synchroniser, so each register update happens in one system clock cycle.

Top module: `nibble_serial_port`

## Requirements
- R1: While `sp_en_n` is high, edges on `sp_clk` and values on `sp_din` have no effect on the registers or on `sp_doe`.
- R2: The first bit of a frame is the direction: 1 = read, 0 = write. The next three bits are the register address, MSB first.
- R3: On a write, bits 5 to 8 are the data nibble, MSB first, and are stored into the addressed register.
- R4: On a read, `sp_doe` rises at the falling edge after the 4th rising edge, and `sp_dout` carries bit 3 there. Bits 2, 1 and 0 follow on the next three falling edges. `sp_doe` falls at the falling edge after the 8th rising edge.
- R5: `sp_doe` is low at all other times, including the whole of a write frame.
- R6: Raising `sp_en_n` partway through a frame clears `sp_doe` at once, and the register bank is not written.
- R7: Register 6 reads as `ro_status`. A write to it has no effect.
- R8: Bit 0 of register 0 always reads 0. Writing a 1 there has no effect.
- R9: After reset, registers 0 to 5 hold 0000: FSK mode, maximum gain, and the other power-up settings.
- R10: A write to address 7 changes nothing. A read of address 7 returns 0000.
- R11: `regs_o` is `{reg6, reg5, ..., reg0}`, with register n at bits [4n+3:4n]. A completed write appears there within a few system clock cycles after the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_en_n | input | 1 | Active-low frame select |
| sp_clk | input | 1 | Host serial clock |
| sp_din | input | 1 | Serial data from host |
| sp_dout | output | 1 | Serial read data |
| sp_doe | output | 1 | Output enable for `sp_dout`; low means high impedance |
| ro_status | input | 4 | Value reported by read-only register 6 |
| regs_o | output | 28 | Register contents, register n at [4n+3:4n] |

## Verification
Assertions check, on every edge, the following behaviours:
- The output enable stays low during the command and write phases, and whenever the select is high.
- The write strobe lasts a single cycle.
- Writes to address 7 leave the bank unchanged.
- The dead bit of register 0 never changes.
- A strobe to a writable address lands its data.

Only the bench scenarios show the following:
- The serial bit order and the exact falling edge on which each read bit appears.
- The abort behaviour at several points in a frame.
- That clock activity with the select high is ignored.
- That register 6 follows its status input.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
    localparam int NIB_W = 4;
    localparam int ADDR_W = 3;
    typedef enum logic [1:0] {PH_CMD, PH_WDATA, PH_RDATA, PH_DONE} nsp_phase_t;
endpackage

// File: rtl/nsp_frontend.sv
module nsp_frontend
    import nsp_pkg::*;
(
    input  logic              rst_n,
    input  logic              sp_en_n,
    input  logic              sp_clk,
    input  logic              sp_din,
    input  logic [NIB_W-1:0]  rd_val,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [NIB_W-1:0]  wr_data,
    output logic              wr_tog,
    output logic              sp_dout,
    output logic              sp_doe
);
    logic            fr_clr;
    nsp_phase_t      phase, phase_nx;
    logic [1:0]      bcnt;
    logic [3:0]      cmd_sh;
    logic [NIB_W-1:0] dat_sh;
    logic [NIB_W-1:0] rd_nib;
    logic            last_bit;

    assign fr_clr   = sp_en_n | ~rst_n;
    assign last_bit = (bcnt == 2'd3);
    assign rd_addr  = cmd_sh[ADDR_W-1:0];

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_CMD:   if (last_bit) phase_nx = cmd_sh[2] ? PH_RDATA : PH_WDATA;
            PH_WDATA: if (last_bit) phase_nx = PH_DONE;
            PH_RDATA: if (last_bit) phase_nx = PH_DONE;
            PH_DONE:  phase_nx = PH_DONE;
        endcase
    end

    // state register: cleared whenever the select is high
    always_ff @(posedge sp_clk or posedge fr_clr) begin
        if (fr_clr) begin
            phase  <= PH_CMD;
            bcnt   <= 2'd0;
            cmd_sh <= '0;
            dat_sh <= '0;
        end else begin
            phase <= phase_nx;
            if (phase != PH_DONE) bcnt <= bcnt + 2'd1;
            if (phase == PH_CMD)   cmd_sh <= {cmd_sh[2:0], sp_din};
            if (phase == PH_WDATA) dat_sh <= {dat_sh[NIB_W-2:0], sp_din};
        end
    end

    // completed write capture: survives the select rising
    always_ff @(posedge sp_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_tog  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (!sp_en_n && phase == PH_WDATA && last_bit) begin
            wr_tog  <= ~wr_tog;
            wr_addr <= cmd_sh[ADDR_W-1:0];
            wr_data <= {dat_sh[NIB_W-2:0], sp_din};
        end
    end

    // output process: falling-edge read driver
    always_ff @(negedge sp_clk or posedge fr_clr) begin
        if (fr_clr) begin
            sp_doe <= 1'b0;
            rd_nib <= '0;
        end else if (phase == PH_RDATA) begin
            sp_doe <= 1'b1;
            rd_nib <= (bcnt == 2'd0) ? rd_val : {rd_nib[NIB_W-2:0], 1'b0};
        end else begin
            sp_doe <= 1'b0;
        end
    end

    assign sp_dout = sp_doe & rd_nib[NIB_W-1];

    assert_write_quiet_R5: assert property (@(posedge sp_clk) disable iff (fr_clr)
        (phase == PH_WDATA) |-> !sp_doe);
    assert_cmd_quiet_R5: assert property (@(posedge sp_clk) disable iff (fr_clr)
        (phase == PH_CMD) |-> !sp_doe);
endmodule

// File: rtl/nsp_sync.sv
module nsp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic stb
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], tog_in};
    end

    assign stb = pipe[STAGES] ^ pipe[STAGES-1];

    assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);
endmodule

// File: rtl/nsp_bank.sv
module nsp_bank
    import nsp_pkg::*;
#(
    parameter int NREG = 7,
    parameter logic [NIB_W-1:0] REG0_MASK = 4'b1110,
    parameter logic [NREG*NIB_W-1:0] RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NIB_W-1:0]      wr_data,
    input  logic [NIB_W-1:0]      ro_status,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [NIB_W-1:0]      rd_val,
    output logic [NREG*NIB_W-1:0] regs_o
);
    localparam int NWR = NREG - 1;
    logic [NWR-1:0][NIB_W-1:0] regs;

    for (genvar i = 0; i < NWR; i++) begin : g_reg
        localparam logic [NIB_W-1:0] MASK = (i == 0) ? REG0_MASK : {NIB_W{1'b1}};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= RST_VAL[i*NIB_W +: NIB_W] & MASK;
            else if (wr_stb && wr_addr == ADDR_W'(i))
                regs[i] <= wr_data & MASK;
        end
        assign regs_o[i*NIB_W +: NIB_W] = regs[i];
    end
    assign regs_o[NWR*NIB_W +: NIB_W] = ro_status;

    always_comb begin
        if (int'(rd_addr) < NWR)       rd_val = regs[rd_addr];
        else if (int'(rd_addr) == NWR) rd_val = ro_status;
        else                           rd_val = '0;
    end

    assert_addr7_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && int'(wr_addr) >= NWR) |=> $stable(regs));
    assert_dead_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (regs[0][0] == $past(regs[0][0])));
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && int'(wr_addr) > 0 && int'(wr_addr) < NWR) |=>
        (regs[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/nibble_serial_port.sv
module nibble_serial_port
    import nsp_pkg::*;
#(
    parameter int NREG = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sp_en_n,
    input  logic                  sp_clk,
    input  logic                  sp_din,
    output logic                  sp_dout,
    output logic                  sp_doe,
    input  logic [NIB_W-1:0]      ro_status,
    output logic [NREG*NIB_W-1:0] regs_o
);
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [NIB_W-1:0]  rd_val, wr_data;
    logic              wr_tog, wr_stb;

    nsp_frontend u_fe (
        .rst_n(rst_n), .sp_en_n(sp_en_n), .sp_clk(sp_clk), .sp_din(sp_din),
        .rd_val(rd_val), .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_tog(wr_tog), .sp_dout(sp_dout), .sp_doe(sp_doe)
    );

    nsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tog_in(wr_tog), .stb(wr_stb)
    );

    nsp_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .ro_status(ro_status), .rd_addr(rd_addr),
        .rd_val(rd_val), .regs_o(regs_o)
    );

    assert_idle_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_en_n |-> !sp_doe);
endmodule

// File: tb/sim_nibble_serial_port.sv
module sim_nibble_serial_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sp_en_n = 1'b1, sp_clk = 1'b0, sp_din = 1'b0;
    logic sp_dout, sp_doe;
    logic [3:0] ro_status = 4'h0;
    logic [27:0] regs_o;
    logic [3:0] model [0:5];
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nibble_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .sp_en_n(sp_en_n), .sp_clk(sp_clk),
        .sp_din(sp_din), .sp_dout(sp_dout), .sp_doe(sp_doe),
        .ro_status(ro_status), .regs_o(regs_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_rd(logic [2:0] a);
        if (a == 3'd6) return ro_status;
        if (a == 3'd7) return 4'h0;
        return model[a];
    endfunction

    function automatic logic [27:0] exp_regs();
        logic [27:0] v;
        for (int i = 0; i < 6; i++) v[i*4 +: 4] = model[i];
        v[27:24] = ro_status;
        return v;
    endfunction

    // nbits < 8 aborts the frame after that many rising edges
    task automatic frame(input logic rw, input logic [2:0] a, input logic [3:0] d,
                         input int nbits, input string req);
        logic [7:0] bits = {rw, a, d};
        logic [3:0] got = 4'h0;
        logic [4:0] oe = 5'h0;
        logic anyoe = 1'b0;
        sp_en_n = 1'b0;
        #20;
        for (int i = 0; i < nbits; i++) begin
            sp_din = bits[7-i];
            #20 sp_clk = 1'b1;
            #20 sp_clk = 1'b0;
            #10;
            if (i >= 3 && i <= 6) got[6-i] = sp_dout;
            if (i >= 3) oe[i-3] = sp_doe;
            anyoe |= sp_doe;
            #10;
        end
        sp_en_n = 1'b1;
        #10;
        chk({req, " R6 released on select"}, sp_doe, 1'b0);
        if (nbits == 8) begin
            if (rw) begin
                chk({req, " R4 read data"}, got, exp_rd(a));
                chk({req, " R4 enable window"}, oe, 5'b01111);
            end else begin
                chk({req, " R5 write keeps hiz"}, anyoe, 1'b0);
                if (a <= 3'd5) model[a] = (a == 3'd0) ? (d & 4'hE) : d;
            end
        end
        #200;
        chk({req, " R11 regs_o"}, regs_o, exp_regs());
    endtask

    initial begin
        for (int i = 0; i < 6; i++) model[i] = 4'h0;
        ro_status = 4'h9;
        #30 rst_n = 1'b1;
        #20;
        chk("R9 reset defaults", regs_o, exp_regs());
        chk("R5 idle hiz", sp_doe, 1'b0);
        // directed
        frame(1'b0, 3'd3, 4'hA, 8, "R3 write r3");
        frame(1'b1, 3'd3, 4'h0, 8, "R2 read r3");
        frame(1'b0, 3'd5, 4'h6, 8, "R3 write r5");
        frame(1'b1, 3'd5, 4'h0, 8, "R4 read r5");
        frame(1'b0, 3'd0, 4'hF, 8, "R8 write r0");
        frame(1'b1, 3'd0, 4'h0, 8, "R8 read r0");
        frame(1'b0, 3'd6, 4'h3, 8, "R7 write r6");
        frame(1'b1, 3'd6, 4'h0, 8, "R7 read r6");
        ro_status = 4'h4;
        frame(1'b1, 3'd6, 4'h0, 8, "R7 read r6 new");
        frame(1'b0, 3'd7, 4'hF, 8, "R10 write a7");
        frame(1'b1, 3'd7, 4'h0, 8, "R10 read a7");
        frame(1'b0, 3'd1, 4'h7, 7, "R6 abort write");
        frame(1'b1, 3'd3, 4'h0, 5, "R6 abort read");
        frame(1'b0, 3'd2, 4'h5, 3, "R6 abort cmd");
        // R1: clocking with select high
        for (int i = 0; i < 16; i++) begin
            sp_din = i[0];
            #20 sp_clk = 1'b1;
            #20 sp_clk = 1'b0;
            #10 chk("R1 ignored doe", sp_doe, 1'b0);
        end
        #100 chk("R1 ignored regs", regs_o, exp_regs());
        // random
        void'($urandom(32'd4711));
        for (int n = 0; n < 60; n++) begin
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic [3:0] d = 4'($urandom);
            logic rw = 1'($urandom);
            ro_status = 4'($urandom);
            frame(rw, a, d, 8, rw ? "R4 random read" : "R3 random write");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule